// File: doc/BRIEF.md
# Configurable Burst Read Address Sequencer

This block sits at the front of a synchronous NOR-style memory model and turns a single read request into a timed stream of word addresses. A 16-bit configuration word, written through a small write port, sets several things: the initial latency, the burst length, linear or interleaved ordering, wrapping, the cycle in which WAIT is raised, and the clock edge on which results change. It also sets whether main-array reads burst synchronously or use the four-word asynchronous page.

When a read starts, the sequencer captures the start address, the main/non-main flag and a snapshot of the configuration word. It counts the latency and then issues one address per clock with a valid strobe and the matching word from an internal lookup. A linear unwrapped synchronous burst that steps across a 16-word row boundary inserts one delay cycle, and the WAIT output flags it. A write that carries a reserved code is refused, and an error pulse reports the refusal.

Top module: `burst_addr_seq`

## Requirements
- R1: After reset the configuration word reads 16'hBBCF, the error flag is low and the valid and WAIT outputs are low.
- R2: A write whose fields are all legal replaces the configuration word, which reads back from the cycle after the write edge.
- R3: A write is refused if any of these hold: bit 14, 10, 5 or 4 is 1; bit 9 is 1; the latency code (bits 13:11) is outside 2, 3 and 4; or the length code (bits 2:0) is outside 1 (4 words), 2 (8 words) and 7 (continuous). A refused write leaves the word unchanged and raises the error flag for exactly the one cycle after the write edge.
- R4: A read started at clock edge 0 gives its first valid beat in the cycle after edge L, where L is the latency code. After that there is one beat per clock, and each beat is held for one clock.
- R5: A synchronous main read (bit 15 = 0) gives 4 or 8 beats and then stops by itself. With length code 7 it runs until the stop input is seen.
- R6: In a fixed-length synchronous burst of N words, the order bit (bit 7) set to 0 makes beat k go to the aligned N-word block base plus (start offset XOR k); wrapping is implied in that case. With bit 7 = 1 and the wrap bit (bit 3) = 0, the offset is (start offset + k) mod N. With bit 7 = 1 and bit 3 = 1, the address is start + k. A continuous burst is always start + k.
- R7: In a linear unwrapped synchronous main burst, a beat at a row-end address (low 4 bits all ones) that is not the last beat is followed by one cycle with no valid beat. If the WAIT bit (bit 8) is 0, WAIT is high during that empty cycle. If it is 1, WAIT is high during the row-end beat.
- R8: With bit 15 = 1, a main read gives exactly 4 beats, linear and wrapped inside the aligned 4-word group, whatever the length, order and wrap fields hold. WAIT stays low.
- R9: A non-main read gives a single beat at the start address after the latency, in any mode.
- R10: Each valid beat carries the data word equal to its address XOR 16'hAAAA.
- R11: With the edge bit (bit 6) = 0, the outputs change on the falling clock edge. With bit 6 = 1, they change just after the rising edge.
- R12: A burst uses the configuration captured when it started; a write during the burst does not change it. A start request while a burst is in progress is ignored.
- R13: The stop input seen at a rising edge during latency or during a burst ends the read, and no further beat follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Configuration write value |
| cfg_q | output | 16 | Current configuration word |
| cfg_err | output | 1 | One-cycle pulse after a refused write |
| rd_start | input | 1 | Start a read (taken only when idle) |
| rd_addr | input | AW | Start word address |
| rd_main | input | 1 | 1 = main-array read, 0 = parameter/status/config read |
| rd_stop | input | 1 | End the current read |
| beat_valid | output | 1 | Address and data of this cycle are a beat |
| beat_wait | output | 1 | WAIT indication around a boundary delay |
| beat_addr | output | AW | Word address of the beat |
| beat_data | output | DW | Word returned by the internal lookup |

## Verification
A latency counter that is off by one moves every beat of a read by a whole cycle, so the valid pattern disagrees from the first expected beat onward. A wrong beat counter or start snapshot corrupts the address and the looked-up data on the very beat where it goes wrong. A boundary-delay flag that is missed, or left set, shifts all later beats of the burst and puts WAIT in the wrong cycle, and that shows within one clock of the row-end beat. A lost configuration snapshot only shows when a write lands mid-burst, which is why that case is driven on purpose.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

  localparam int unsigned CFG_W     = 16;
  localparam logic [15:0] CFG_RESET = 16'hBBCF;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_LAT  = 2'd1,
    SQ_BEAT = 2'd2
  } sq_state_t;

  // reserved bits, latency set {2,3,4}, length set {1,2,7}, output-hold bit
  function automatic logic cfg_legal(input logic [15:0] c);
    logic ok;
    ok = 1'b1;
    if (c[14] || c[10] || c[5] || c[4]) ok = 1'b0;
    if (c[9]) ok = 1'b0;
    case (c[13:11])
      3'd2, 3'd3, 3'd4: ;
      default: ok = 1'b0;
    endcase
    case (c[2:0])
      3'd1, 3'd2, 3'd7: ;
      default: ok = 1'b0;
    endcase
    return ok;
  endfunction

  function automatic logic [2:0] latency_code(input logic [15:0] c);
    return c[13:11];
  endfunction

  function automatic logic wait_early(input logic [15:0] c);
    return c[8];
  endfunction

  function automatic logic rise_edge(input logic [15:0] c);
    return c[6];
  endfunction

  // beats per read; 0 stands for continuous
  function automatic logic [3:0] burst_words(input logic [15:0] c, input logic main);
    logic [3:0] n;
    if (!main)       n = 4'd1;
    else if (c[15])  n = 4'd4;
    else begin
      case (c[2:0])
        3'd1:    n = 4'd4;
        3'd2:    n = 4'd8;
        default: n = 4'd0;
      endcase
    end
    return n;
  endfunction

  function automatic logic order_xor(input logic [15:0] c, input logic main);
    return main && !c[15] && !c[7];
  endfunction

  function automatic logic order_wrap(input logic [15:0] c, input logic main);
    return main && (c[15] || !c[3]);
  endfunction

  // linear, unwrapped, synchronous main read: the only kind with row delays
  function automatic logic gap_capable(input logic [15:0] c, input logic main);
    return main && !c[15] &&
           ((burst_words(c, main) == 4'd0) || (c[7] && c[3]));
  endfunction

endpackage

// File: rtl/bseq_cfg_reg.sv
module bseq_cfg_reg
  import bseq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output logic [CFG_W-1:0] cfg_q,
  output logic             err_pulse,
  output logic             wr_reject
);

  logic wr_accept;

  assign wr_accept = we &&  cfg_legal(wdata);
  assign wr_reject = we && !cfg_legal(wdata);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q     <= CFG_RESET;
      err_pulse <= 1'b0;
    end else begin
      if (wr_accept) cfg_q <= wdata;
      err_pulse <= wr_reject;
    end
  end

endmodule

// File: rtl/bseq_addr_gen.sv
module bseq_addr_gen #(
  parameter int unsigned AW        = 16,
  parameter int unsigned ROW_WORDS = 16
) (
  input  logic [AW-1:0] start,
  input  logic [AW-1:0] beat,
  input  logic [3:0]    words,
  input  logic          use_xor,
  input  logic          use_wrap,
  output logic [AW-1:0] addr,
  output logic          row_end
);

  localparam int unsigned ROW_B = $clog2(ROW_WORDS);

  function automatic logic [AW-1:0] beat_address(
    input logic [AW-1:0] s,
    input logic [AW-1:0] k,
    input logic [3:0]    n,
    input logic          x,
    input logic          w
  );
    logic [AW-1:0] mask;
    logic [AW-1:0] lin;
    logic [AW-1:0] res;
    mask = AW'(n) - AW'(1);
    lin  = s + k;
    if (n <= 4'd1)  res = lin;
    else if (x)     res = (s & ~mask) | ((s ^ k) & mask);
    else if (w)     res = (s & ~mask) | (lin & mask);
    else            res = lin;
    return res;
  endfunction

  assign addr    = beat_address(start, beat, words, use_xor, use_wrap);
  assign row_end = &addr[ROW_B-1:0];

endmodule

// File: rtl/bseq_ctrl.sv
module bseq_ctrl
  import bseq_pkg::*;
#(
  parameter int unsigned AW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] cfg,
  input  logic             rd_start,
  input  logic [AW-1:0]    rd_addr,
  input  logic             rd_main,
  input  logic             rd_stop,
  input  logic             row_end,
  output sq_state_t        state,
  output logic [CFG_W-1:0] snap_cfg,
  output logic [AW-1:0]    snap_start,
  output logic             snap_main,
  output logic [AW-1:0]    beat,
  output logic [3:0]       words,
  output logic             seq_valid,
  output logic             seq_wait,
  output logic             ev_cross,
  output logic             ev_last
);

  logic [2:0] lat_cnt;
  logic       dly;
  logic       gap_ok;

  assign words  = burst_words(snap_cfg, snap_main);
  assign gap_ok = gap_capable(snap_cfg, snap_main);

  always_comb begin
    seq_valid = (state == SQ_BEAT) && !dly;
    ev_last   = (words != 4'd0) && (beat == AW'(words - 4'd1));
    ev_cross  = seq_valid && gap_ok && row_end && !ev_last;
    seq_wait  = wait_early(snap_cfg) ? ev_cross : ((state == SQ_BEAT) && dly);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= SQ_IDLE;
      snap_cfg   <= CFG_RESET;
      snap_start <= '0;
      snap_main  <= 1'b0;
      beat       <= '0;
      lat_cnt    <= '0;
      dly        <= 1'b0;
    end else begin
      case (state)
        SQ_IDLE: begin
          if (rd_start) begin
            snap_cfg   <= cfg;
            snap_start <= rd_addr;
            snap_main  <= rd_main;
            beat       <= '0;
            dly        <= 1'b0;
            lat_cnt    <= latency_code(cfg);
            state      <= SQ_LAT;
          end
        end
        SQ_LAT: begin
          if (rd_stop)               state   <= SQ_IDLE;
          else if (lat_cnt <= 3'd1)  state   <= SQ_BEAT;
          else                       lat_cnt <= lat_cnt - 3'd1;
        end
        SQ_BEAT: begin
          if (rd_stop) begin
            state <= SQ_IDLE;
            dly   <= 1'b0;
          end else if (dly) begin
            dly <= 1'b0;
          end else if (ev_last) begin
            state <= SQ_IDLE;
          end else begin
            beat <= beat + AW'(1);
            dly  <= ev_cross;
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/bseq_out_stage.sv
module bseq_out_stage #(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rise_mode,
  input  logic          in_valid,
  input  logic          in_wait,
  input  logic [AW-1:0] in_addr,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  output logic          out_wait,
  output logic [AW-1:0] out_addr,
  output logic [DW-1:0] out_data
);

  logic          n_valid;
  logic          n_wait;
  logic [AW-1:0] n_addr;
  logic [DW-1:0] n_data;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_valid <= 1'b0;
      n_wait  <= 1'b0;
      n_addr  <= '0;
      n_data  <= '0;
    end else begin
      n_valid <= in_valid;
      n_wait  <= in_wait;
      n_addr  <= in_addr;
      n_data  <= in_data;
    end
  end

  assign out_valid = rise_mode ? in_valid : n_valid;
  assign out_wait  = rise_mode ? in_wait  : n_wait;
  assign out_addr  = rise_mode ? in_addr  : n_addr;
  assign out_data  = rise_mode ? in_data  : n_data;

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import bseq_pkg::*;
#(
  parameter int unsigned AW        = 16,
  parameter int unsigned DW        = 16,
  parameter int unsigned ROW_WORDS = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [15:0]   cfg_wdata,
  output logic [15:0]   cfg_q,
  output logic          cfg_err,
  input  logic          rd_start,
  input  logic [AW-1:0] rd_addr,
  input  logic          rd_main,
  input  logic          rd_stop,
  output logic          beat_valid,
  output logic          beat_wait,
  output logic [AW-1:0] beat_addr,
  output logic [DW-1:0] beat_data
);

  function automatic logic [DW-1:0] word_at(input logic [AW-1:0] a);
    logic [DW-1:0] w;
    for (int i = 0; i < DW; i++) w[i] = a[i % AW] ^ ((i % 2) == 1);
    return w;
  endfunction

  sq_state_t        seq_state;
  logic [CFG_W-1:0] snap_cfg;
  logic [AW-1:0]    snap_start;
  logic             snap_main;
  logic [AW-1:0]    seq_beat;
  logic [3:0]       seq_words;
  logic             seq_valid;
  logic             seq_wait;
  logic             seq_cross;
  logic             seq_last;
  logic [AW-1:0]    seq_addr;
  logic             seq_row_end;
  logic [DW-1:0]    seq_data;
  logic             cfg_reject;

  bseq_cfg_reg u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (cfg_we),
    .wdata     (cfg_wdata),
    .cfg_q     (cfg_q),
    .err_pulse (cfg_err),
    .wr_reject (cfg_reject)
  );

  bseq_ctrl #(.AW(AW)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg        (cfg_q),
    .rd_start   (rd_start),
    .rd_addr    (rd_addr),
    .rd_main    (rd_main),
    .rd_stop    (rd_stop),
    .row_end    (seq_row_end),
    .state      (seq_state),
    .snap_cfg   (snap_cfg),
    .snap_start (snap_start),
    .snap_main  (snap_main),
    .beat       (seq_beat),
    .words      (seq_words),
    .seq_valid  (seq_valid),
    .seq_wait   (seq_wait),
    .ev_cross   (seq_cross),
    .ev_last    (seq_last)
  );

  bseq_addr_gen #(.AW(AW), .ROW_WORDS(ROW_WORDS)) u_agen (
    .start    (snap_start),
    .beat     (seq_beat),
    .words    (seq_words),
    .use_xor  (order_xor(snap_cfg, snap_main)),
    .use_wrap (order_wrap(snap_cfg, snap_main)),
    .addr     (seq_addr),
    .row_end  (seq_row_end)
  );

  assign seq_data = word_at(seq_addr);

  bseq_out_stage #(.AW(AW), .DW(DW)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .rise_mode (rise_edge(snap_cfg)),
    .in_valid  (seq_valid),
    .in_wait   (seq_wait),
    .in_addr   (seq_addr),
    .in_data   (seq_data),
    .out_valid (beat_valid),
    .out_wait  (beat_wait),
    .out_addr  (beat_addr),
    .out_data  (beat_data)
  );

endmodule

// File: rtl/bseq_chk.sv
module bseq_chk
  import bseq_pkg::*;
#(
  parameter int unsigned AW = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_we,
  input logic             cfg_reject,
  input logic [15:0]      cfg_q,
  input logic             cfg_err,
  input logic             rd_stop,
  input logic [1:0]       state,
  input logic [CFG_W-1:0] snap_cfg,
  input logic             snap_main,
  input logic             seq_valid,
  input logic             seq_wait,
  input logic             seq_cross,
  input logic             seq_last,
  input logic [AW-1:0]    seq_addr
);

  AST_ERR_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> $past(cfg_we) && $past(cfg_reject)); // R3

  AST_REJECT_KEEPS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> $stable(cfg_q)); // R3

  AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_valid && $past(seq_valid) && gap_capable(snap_cfg, snap_main))
      |-> seq_addr == $past(seq_addr) + AW'(1)); // R6

  AST_GAP_AFTER_CROSS: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_cross && !rd_stop) |=> !seq_valid); // R7

  AST_WAIT_NO_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_wait && !wait_early(snap_cfg)) |-> !seq_valid); // R7

  AST_PAGE_NO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    snap_cfg[15] |-> !seq_wait); // R8

  AST_SINGLE_NONMAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_valid && !snap_main) |=> !seq_valid); // R9

  AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_valid && seq_last) |=> !seq_valid); // R5

  AST_STOP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stop && state != 2'd0) |=> !seq_valid && state == 2'd0); // R13

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'd0) |-> !seq_valid && !seq_wait); // R13

endmodule

bind burst_addr_seq bseq_chk #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_we     (cfg_we),
  .cfg_reject (cfg_reject),
  .cfg_q      (cfg_q),
  .cfg_err    (cfg_err),
  .rd_stop    (rd_stop),
  .state      (seq_state),
  .snap_cfg   (snap_cfg),
  .snap_main  (snap_main),
  .seq_valid  (seq_valid),
  .seq_wait   (seq_wait),
  .seq_cross  (seq_cross),
  .seq_last   (seq_last),
  .seq_addr   (seq_addr)
);

// File: tb/sim_burst_addr_seq.sv
module sim_burst_addr_seq;

  localparam int WIN = 24;
  localparam int NV  = 8;

  typedef struct packed {
    logic [15:0] cfg;
    logic [15:0] start;
    logic        main;
    logic [7:0]  take;
  } vec_t;

  // cfg, start, main, beats to take before stop (0 = fixed length)
  localparam vec_t VECS [NV] = '{
    '{16'h10C1, 16'h0006, 1'b1, 8'd0},   // R6 linear wrap 4
    '{16'h1842, 16'h0105, 1'b1, 8'd0},   // R6 interleaved 8
    '{16'h21CA, 16'h001D, 1'b1, 8'd0},   // R7 unwrapped, WAIT early
    '{16'h20CA, 16'h003E, 1'b1, 8'd0},   // R7 unwrapped, WAIT in delay
    '{16'h11CF, 16'h00FC, 1'b1, 8'd10},  // R5 continuous, R13 stop
    '{16'h98CA, 16'h0042, 1'b1, 8'd0},   // R8 page mode
    '{16'h21CA, 16'h0077, 1'b0, 8'd0},   // R9 non-main
    '{16'h1049, 16'h0203, 1'b1, 8'd0}    // R6 interleaved, wrap bit ignored
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_q;
  logic        cfg_err;
  logic        rd_start = 1'b0;
  logic [15:0] rd_addr = '0;
  logic        rd_main = 1'b0;
  logic        rd_stop = 1'b0;
  logic        beat_valid;
  logic        beat_wait;
  logic [15:0] beat_addr;
  logic [15:0] beat_data;

  int n_chk = 0;
  int n_bad = 0;

  bit          ev [WIN];
  bit          ew [WIN];
  logic [15:0] ea [WIN];
  int          stop_cyc;
  int          lat_exp;

  always #10ns clk = ~clk;

  burst_addr_seq u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_wdata  (cfg_wdata),
    .cfg_q      (cfg_q),
    .cfg_err    (cfg_err),
    .rd_start   (rd_start),
    .rd_addr    (rd_addr),
    .rd_main    (rd_main),
    .rd_stop    (rd_stop),
    .beat_valid (beat_valid),
    .beat_wait  (beat_wait),
    .beat_addr  (beat_addr),
    .beat_data  (beat_data)
  );

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #15ns;
  endtask

  task automatic wr(input logic [15:0] c);
    cfg_we = 1'b1;
    cfg_wdata = c;
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic build(input logic [15:0] c, input logic [15:0] s,
                       input bit m, input int take);
    int n, cyc, cnt, a, si;
    bit ilv, wrp, gaps, more;
    for (int j = 0; j < WIN; j++) begin ev[j] = 0; ew[j] = 0; ea[j] = '0; end
    si = int'(s);
    lat_exp = int'(c[13:11]);
    if (!m)          begin n = 1; ilv = 0; wrp = 0; end
    else if (c[15])  begin n = 4; ilv = 0; wrp = 1; end
    else begin
      n = (c[2:0] == 3'd1) ? 4 : (c[2:0] == 3'd2) ? 8 : 0;
      ilv = !c[7];
      wrp = !c[3];
    end
    gaps = m && !c[15] && (n == 0 || (!ilv && !wrp));
    cnt = (n == 0) ? take : n;
    cyc = lat_exp;
    stop_cyc = -1;
    for (int k = 0; k < cnt; k++) begin
      if (n <= 1)    a = si + k;
      else if (ilv)  a = (si / n) * n + ((si % n) ^ k);
      else if (wrp)  a = (si / n) * n + (((si % n) + k) % n);
      else           a = si + k;
      ev[cyc] = 1;
      ea[cyc] = 16'(a);
      more = (n == 0) || (k < cnt - 1);
      if (k == cnt - 1) stop_cyc = cyc;
      if (gaps && more && ((a % 16) == 15)) begin
        if (c[8]) ew[cyc] = 1;
        if (k < cnt - 1) begin
          cyc++;
          if (!c[8]) ew[cyc] = 1;
        end
      end
      cyc++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] prev;
    logic [15:0] bad_words [4];
    string vtag, atag;

    repeat (3) @(posedge clk);
    #15ns;
    rst_n = 1'b1;
    tick();

    // R1 reset state
    check(cfg_q == 16'hBBCF, "R1", "cfg reset", cfg_q, 16'hBBCF);
    check(cfg_err == 1'b0, "R1", "err reset", cfg_err, 0);
    check(beat_valid == 1'b0, "R1", "valid reset", beat_valid, 0);
    check(beat_wait == 1'b0, "R1", "wait reset", beat_wait, 0);

    // R3 refused writes
    bad_words[0] = 16'h50C1;  // reserved bit 14
    bad_words[1] = 16'h28C1;  // latency code 5
    bad_words[2] = 16'h10C3;  // length code 3
    bad_words[3] = 16'h12C1;  // hold bit 9
    for (int b = 0; b < 4; b++) begin
      prev = cfg_q;
      wr(bad_words[b]);
      check(cfg_err == 1'b1, "R3", "err pulse", cfg_err, 1);
      check(cfg_q == prev, "R3", "word kept", cfg_q, prev);
      tick();
      check(cfg_err == 1'b0, "R3", "err one cycle", cfg_err, 0);
    end

    // table of reads
    for (int vi = 0; vi < NV; vi++) begin
      wr(VECS[vi].cfg);
      check(cfg_q == VECS[vi].cfg, "R2", "cfg readback", cfg_q, VECS[vi].cfg);
      check(cfg_err == 1'b0, "R2", "no err on legal", cfg_err, 0);
      build(VECS[vi].cfg, VECS[vi].start, VECS[vi].main, int'(VECS[vi].take));
      rd_start = 1'b1;
      rd_addr  = VECS[vi].start;
      rd_main  = VECS[vi].main;
      tick();
      rd_start = 1'b0;
      for (int j = 0; j < WIN; j++) begin
        if (!VECS[vi].main)                              vtag = "R9";
        else if (VECS[vi].cfg[15])                       vtag = "R8";
        else if (j <= lat_exp)                           vtag = "R4";
        else if (VECS[vi].take != 0 && j > stop_cyc)     vtag = "R13";
        else                                             vtag = "R5";
        atag = !VECS[vi].main ? "R9" : VECS[vi].cfg[15] ? "R8" : "R6";
        check(beat_valid == ev[j], vtag, $sformatf("valid v%0d c%0d", vi, j), beat_valid, ev[j]);
        if (ev[j]) begin
          check(beat_addr == ea[j], atag, $sformatf("addr v%0d c%0d", vi, j), beat_addr, ea[j]);
          check(beat_data == (ea[j] ^ 16'hAAAA), "R10", "data", beat_data, ea[j] ^ 16'hAAAA);
        end
        check(beat_wait == ew[j], "R7", $sformatf("wait v%0d c%0d", vi, j), beat_wait, ew[j]);
        if (VECS[vi].take != 0 && j == stop_cyc) rd_stop = 1'b1;
        tick();
        rd_stop = 1'b0;
      end
    end

    // R11 falling-edge output versus rising-edge output
    for (int e = 0; e < 2; e++) begin
      wr(e == 0 ? 16'h1081 : 16'h10C1);
      rd_start = 1'b1;
      rd_addr  = 16'h0010;
      rd_main  = 1'b1;
      tick();
      rd_start = 1'b0;
      @(posedge clk);
      @(posedge clk);
      #5ns;
      check(beat_valid == (e == 1), "R11", "valid early in cycle", beat_valid, (e == 1));
      #10ns;
      check(beat_valid == 1'b1, "R11", "valid late in cycle", beat_valid, 1);
      check(beat_addr == 16'h0010, "R11", "addr", beat_addr, 16'h0010);
      repeat (6) tick();
    end

    // R12 snapshot and start while busy
    wr(16'h10C1);
    rd_start = 1'b1;
    rd_addr  = 16'h0006;
    rd_main  = 1'b1;
    tick();
    rd_start = 1'b0;
    tick();
    tick();
    check(beat_valid && beat_addr == 16'h0006, "R12", "first beat", beat_addr, 16'h0006);
    tick();
    cfg_we    = 1'b1;
    cfg_wdata = 16'h21CA;
    rd_start  = 1'b1;
    rd_addr   = 16'h0050;
    tick();
    cfg_we   = 1'b0;
    rd_start = 1'b0;
    check(cfg_q == 16'h21CA, "R2", "mid-burst write", cfg_q, 16'h21CA);
    check(beat_valid && beat_addr == 16'h0004, "R12", "beat 2 old order", beat_addr, 16'h0004);
    tick();
    check(beat_valid && beat_addr == 16'h0005, "R12", "beat 3 old order", beat_addr, 16'h0005);
    for (int j = 0; j < 12; j++) begin
      tick();
      check(beat_valid == 1'b0, "R12", "no restart", beat_valid, 0);
    end

    // R13 stop during latency
    rd_start = 1'b1;
    rd_addr  = 16'h0030;
    tick();
    rd_start = 1'b0;
    rd_stop  = 1'b1;
    tick();
    rd_stop  = 1'b0;
    for (int j = 0; j < 10; j++) begin
      check(beat_valid == 1'b0, "R13", "stopped in latency", beat_valid, 0);
      tick();
    end

    summary();
    $finish;
  end

endmodule